// File: doc/BRIEF.md
# Page-Mode Parallel Memory Read Controller

This block sits between an internal request bus and the pins of an asynchronous parallel memory that offers page-mode reads. A client presents a word address with a valid/ready handshake; the controller drives chip select, output enable and the address onto the memory pins, counts a number of wait cycles, samples the data bus and returns the word with a one-cycle response strobe. Writes, command sequences, erase and program are not handled here.

A page is four consecutive words. The upper address bits pick the page and the two lowest bits pick the word inside it. The controller remembers which page is open. When a new request falls in that page and chip select has stayed asserted since the page was opened, only the short page wait is spent; every other request pays the full random-access wait. After a configurable run of idle cycles the controller releases chip select so the memory can drop to standby with its outputs floating, and the open page is forgotten at the same moment.

Top module: `pgrd_ctrl`

## Requirements
- R1: A synchronous active-high reset sets mem_ce_n and mem_oe_n to 1, rsp_valid to 0, req_ready to 1 and closes the page, so the first read after reset, even mid-access, takes the full wait.
- R2: req_ready is 1 only when no access is in progress; a request is accepted on a clock edge where req_valid and req_ready are both 1, and after that edge mem_addr equals the request address while mem_ce_n and mem_oe_n are 0.
- R3: A read whose page (req_addr[ADDR_W-1:2]) differs from the open page, or arrives with no page open, raises rsp_valid after the FULL_WAIT-th clock edge following the accepting edge (default 6).
- R4: A read whose page equals the open page, with chip select held asserted since that page was opened, raises rsp_valid after the PAGE_WAIT-th edge following acceptance (default 2).
- R5: The word select req_addr[1:0] (00 word 0, 01 word 1, 10 word 2, 11 word 3) is driven unchanged onto mem_addr[1:0], and words of one page hit in any order.
- R6: rsp_data equals mem_data sampled on the final wait edge, and rsp_valid stays high for exactly one cycle.
- R7: mem_oe_n is 0 only while mem_ce_n is 0 and an access is in progress; it returns to 1 on the edge that samples the data.
- R8: After IDLE_LIMIT consecutive idle clock edges without an accepted request (default 4), mem_ce_n goes to 1 and the page closes, so a later read of the same page takes the full wait.
- R9: A request accepted on the very edge at which the idle limit would be reached takes precedence: chip select stays asserted, the page stays open and the read takes the page wait.
- R10: mem_addr stays constant for every cycle in which mem_oe_n is 0.
- R11: A new request may be accepted in the same cycle in which rsp_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | One-cycle strobe: rsp_data holds the read word |
| rsp_data | output | DATA_W | Returned read data |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory word address |
| mem_data | input | DATA_W | Memory data bus |

## Verification
Two functions meet in one cycle here: the idle timer reaching its limit and a new request being accepted on the same edge. The bench provokes it by leaving exactly IDLE_LIMIT-1 idle edges after a response and then presenting a same-page request, and judges it by checking that chip select was still low just before acceptance and that the read completes after the short page wait; one more idle edge must instead show chip select released and a full wait. A second coincidence, a request presented while rsp_valid is high, is exercised by back-to-back reads.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

  typedef enum logic {
    PG_IDLE = 1'b0,
    PG_WAIT = 1'b1
  } pg_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgrd_page_track.sv
module pgrd_page_track #(
  parameter int PAGE_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_en,
  input  logic              close_en,
  input  logic [PAGE_W-1:0] req_page,
  output logic              hit
);

  logic [PAGE_W-1:0] open_page;
  logic              open_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_page <= '0;
      open_vld  <= 1'b0;
    end else if (open_en) begin
      open_page <= req_page;
      open_vld  <= 1'b1;
    end else if (close_en) begin
      open_vld  <= 1'b0;
    end
  end

  assign hit = open_vld && (open_page == req_page);

endmodule

// File: rtl/pgrd_wait_timer.sv
module pgrd_wait_timer #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              last
);

  logic [WAIT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign last = (remain == WAIT_W'(1));

endmodule

// File: rtl/pgrd_idle_timer.sv
module pgrd_idle_timer #(
  parameter int LIMIT  = 4,
  parameter int IDLE_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expire
);

  logic [IDLE_W-1:0] idle_cnt;

  assign expire = run && (idle_cnt == IDLE_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clear || expire) begin
      idle_cnt <= '0;
    end else if (run) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl
  import pgrd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int WSEL_W     = 2,
  parameter int FULL_WAIT  = 6,
  parameter int PAGE_WAIT  = 2,
  parameter int IDLE_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_data
);

  localparam int PAGE_W   = ADDR_W - WSEL_W;
  localparam int MAX_WAIT = max2(FULL_WAIT, PAGE_WAIT);
  localparam int WAIT_W   = $clog2(MAX_WAIT + 1);
  localparam int IDLE_W   = $clog2(IDLE_LIMIT + 1);

  pg_state_e         state;
  logic              accept;
  logic              page_hit;
  logic              wait_last;
  logic              idle_run;
  logic              idle_expire;
  logic [WAIT_W-1:0] wait_val;

  assign req_ready = (state == PG_IDLE);
  assign accept    = req_valid && req_ready;
  assign idle_run  = (state == PG_IDLE) && !mem_ce_n && !accept;
  assign wait_val  = page_hit ? WAIT_W'(PAGE_WAIT) : WAIT_W'(FULL_WAIT);

  pgrd_page_track #(.PAGE_W(PAGE_W)) u_page (
    .clk      (clk),
    .rst      (rst),
    .open_en  (accept),
    .close_en (idle_expire),
    .req_page (req_addr[ADDR_W-1:WSEL_W]),
    .hit      (page_hit)
  );

  pgrd_wait_timer #(.WAIT_W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (wait_val),
    .last     (wait_last)
  );

  pgrd_idle_timer #(.LIMIT(IDLE_LIMIT), .IDLE_W(IDLE_W)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .run    (idle_run),
    .expire (idle_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PG_IDLE;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        PG_IDLE: begin
          if (accept) begin
            state    <= PG_WAIT;
            mem_ce_n <= 1'b0;
            mem_oe_n <= 1'b0;
            mem_addr <= req_addr;
          end else if (idle_expire) begin
            mem_ce_n <= 1'b1;
          end
        end
        PG_WAIT: begin
          if (wait_last) begin
            state     <= PG_IDLE;
            mem_oe_n  <= 1'b1;
            rsp_valid <= 1'b1;
            rsp_data  <= mem_data;
          end
        end
        default: state <= PG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pgrd_ctrl_chk.sv
module pgrd_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr
);

  AST_OE_INSIDE_CE: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_ce_n); // R7

  AST_OE_AT_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $rose(mem_oe_n)); // R7

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R6

  AST_ACCEPT_PINS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!mem_ce_n && !mem_oe_n && mem_addr == $past(req_addr))); // R2

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !req_ready); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr)); // R10

  AST_CE_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ce_n) |-> (req_ready && mem_oe_n)); // R8

  logic unused_ok;
  assign unused_ok = ^rsp_data;

endmodule

bind pgrd_ctrl pgrd_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_addr  (mem_addr)
);

// File: tb/pgrd_ctrl_test.sv
`timescale 1ns/1ps
module pgrd_ctrl_test;

  localparam int AW    = 20;
  localparam int DW    = 16;
  localparam int FULL  = 6;
  localparam int PAGE  = 2;
  localparam int LIMIT = 4;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [3:0]    gap;
    logic          hit;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{20'h00100, 4'd0, 1'b0},
    '{20'h00101, 4'd0, 1'b1},
    '{20'h00103, 4'd0, 1'b1},
    '{20'h00102, 4'd0, 1'b1},
    '{20'h00104, 4'd0, 1'b0},
    '{20'h00100, 4'd0, 1'b0},
    '{20'h00101, 4'd1, 1'b1},
    '{20'h00102, 4'd3, 1'b1},
    '{20'h00103, 4'd4, 1'b0},
    '{20'h3FFFC, 4'd0, 1'b0},
    '{20'h3FFFF, 4'd0, 1'b1},
    '{20'hFFFFF, 4'd2, 1'b0},
    '{20'hFFFFC, 4'd0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          mem_ce_n;
  logic          mem_oe_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] mdl(input logic [AW-1:0] a);
    return a[15:0] ^ {a[19:16], a[19:16], 8'h3C};
  endfunction

  assign mem_data = (!mem_ce_n && !mem_oe_n) ? mdl(mem_addr) : 16'hBAD0;

  pgrd_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .WSEL_W(2),
    .FULL_WAIT(FULL), .PAGE_WAIT(PAGE), .IDLE_LIMIT(LIMIT)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_data(mem_data)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Starts at a negedge; returns at the negedge where rsp_valid is seen.
  task automatic do_read(input logic [AW-1:0] a, input int gap, input logic exp_hit,
                         input logic chk_b2b);
    int  lat;
    logic hold_ok;
    if (chk_b2b)
      check(req_ready && rsp_valid, "R11 ready during response", {req_ready, rsp_valid}, 2'b11);
    repeat (gap) @(negedge clk);
    if (gap >= LIMIT)
      check(mem_ce_n && mem_oe_n, "R8 chip select released after idle", mem_ce_n, 1);
    if (gap == LIMIT - 1)
      check(!mem_ce_n, "R9 chip select held at collision edge", mem_ce_n, 0);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    hold_ok = 1'b1;
    while (!rsp_valid && lat < 40) begin
      if (mem_oe_n || mem_ce_n || req_ready || mem_addr != a) hold_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    check(lat == (exp_hit ? PAGE : FULL), exp_hit ? "R4 page-hit latency" : "R3 full latency",
          lat, exp_hit ? PAGE : FULL);
    check(rsp_data == mdl(a), "R6 read data", rsp_data, mdl(a));
    check(hold_ok, "R10 R5 R7 pins held during access", {31'd0, hold_ok}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(mem_ce_n == 1'b1 && mem_oe_n == 1'b1, "R1 reset pins", {mem_ce_n, mem_oe_n}, 2'b11);
    check(!rsp_valid && req_ready, "R1 reset handshake", {rsp_valid, req_ready}, 2'b01);
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      do_read(VECS[i].addr, int'(VECS[i].gap), VECS[i].hit, (i > 0) && (VECS[i].gap == 0));

    @(negedge clk);
    check(!rsp_valid, "R6 response is one cycle", rsp_valid, 0);
    check(mem_oe_n && !mem_ce_n, "R7 oe released, ce held between reads", {mem_ce_n, mem_oe_n}, 2'b01);

    // word select passes straight through (R5)
    req_valid = 1'b1;
    req_addr  = 20'hFFFFE;
    @(negedge clk);
    req_valid = 1'b0;
    check(mem_addr[1:0] == 2'b10 && !mem_oe_n, "R5 word select on pins", mem_addr[1:0], 2'b10);
    check(!req_ready, "R2 not ready while busy", req_ready, 0);
    // reset in the middle of the access (R1)
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(mem_ce_n && mem_oe_n && !rsp_valid && req_ready, "R1 reset mid-access",
          {mem_ce_n, mem_oe_n, rsp_valid, req_ready}, 4'b1101);
    rst = 1'b0;
    do_read(20'hFFFFD, 0, 1'b0, 1'b0);
    do_read(20'hFFFFC, 0, 1'b1, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule